// File: doc/BRIEF.md
# Two-Wire Bus Arbitration Loss Monitor

This block watches a master's own transmission on a wired-AND two-wire bus (clock line SCL, data line SDA). On every rising edge of SCL it compares the bit the master is driving with the level actually present on SDA. A master that drives a 1 but reads a 0 has lost the bus to another master. The block turns that finding into an arbitration-lost flag, and it can also withdraw the master's SDA drive.

The flag follows one of two policies, chosen by `mode_byte`. In per-bit mode, each compared bit rewrites the flag. In per-byte mode, the block latches any loss within the frame and posts it to the flag on the falling edge of the ninth SCL clock. After that the flag stays set until software clears it. When `release_en` is set, the `sda_oe` gate drops in the same cycle the flag is set. It stays low until software clears the flag or a new frame starts. SCL and SDA must already be synchronized to `clk`. Byte shifting and acknowledge handling are outside the block.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, `arb_lost` is 0 and `sda_oe` is 1.
- R2: With `mode_byte`=0, every SCL rising edge seen while `tx_active`=1 rewrites `arb_lost`: it becomes 1 if `tx_bit`=1 and `sda_in`=0 at that edge, and 0 otherwise. The new value is visible one `clk` cycle after the edge is sampled.
- R3: Only the pair `tx_bit`=1 / `sda_in`=0 counts as a loss. Driving 0 while reading 1 is not a loss. SCL edges seen while `tx_active`=0 leave `arb_lost` unchanged.
- R4: With `mode_byte`=1, `arb_lost` does not change on SCL rising edges or on the falling edges of clocks 1 to 8. On the falling edge of the ninth clock after a frame start, it is set if any loss was seen since that frame start.
- R5: With `mode_byte`=1, a set `arb_lost` is not cleared by later frames that have no loss. Only `flag_clr` clears it.
- R6: `frame_start` resets the ninth-clock counter and forgets any loss seen earlier, so a loss from a previous frame is never posted.
- R7: With `release_en`=1, `sda_oe` goes to 0 in the same cycle that `arb_lost` is set. With `release_en`=0, `sda_oe` stays 1.
- R8: Once `sda_oe` is 0, it stays 0 until `flag_clr` or `frame_start`, even if a per-bit update clears `arb_lost`.
- R9: `flag_clr` clears `arb_lost` and wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| tx_active | input | 1 | 1 while this master is transmitting |
| tx_bit | input | 1 | Bit currently being driven on SDA |
| frame_start | input | 1 | One-cycle strobe at the start of each 9-clock frame |
| flag_clr | input | 1 | Software clear of the arbitration-lost flag |
| mode_byte | input | 1 | 0: flag updated per bit; 1: sticky, posted at the ninth falling edge |
| release_en | input | 1 | 1: release SDA on loss |
| arb_lost | output | 1 | Arbitration-lost flag |
| sda_oe | output | 1 | SDA drive gate; 0 forces SDA to high impedance |

## Verification
The bench sweeps all combinations of prior flag, `tx_active`, `tx_bit` and `sda_in` in per-bit mode. A compare with the wrong polarity, or one that ignores `tx_active`, shows up as a flag that is set or cleared on the wrong edge. In per-byte mode it places a single loss at every bit position 1 to 9 and checks the flag after every edge. A design that posts early, or at the wrong falling edge, would raise the flag before the ninth fall. The bench also checks that a posted flag survives a clean frame, and that a loss seen before `frame_start` is dropped; a stale latch would post it. Further checks confirm that `sda_oe` stays low after a per-bit clear, and that a clear in the same cycle as a loss wins.

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic tx_active,
  input  logic tx_bit,
  input  logic frame_start,
  input  logic flag_clr,
  input  logic mode_byte,
  input  logic release_en,
  output logic arb_lost,
  output logic sda_oe
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic scl_q, miss_seen, released;
  logic [CW-1:0] bit_cnt;

  wire rise     = scl_in & ~scl_q & ~frame_start;
  wire fall     = ~scl_in & scl_q & ~frame_start;
  wire compare  = rise & tx_active;
  wire mismatch = compare & tx_bit & ~sda_in;
  wire bit_set  = ~mode_byte & mismatch;
  wire bit_clr  = ~mode_byte & compare & ~mismatch;
  wire byte_set = mode_byte & fall & (bit_cnt == LAST) & miss_seen;
  wire set_ev   = bit_set | byte_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      bit_cnt   <= '0;
      miss_seen <= 1'b0;
    end else begin
      scl_q <= scl_in;
      if (frame_start) begin
        bit_cnt   <= '0;
        miss_seen <= 1'b0;
      end else begin
        if (rise && bit_cnt != CMAX) bit_cnt <= bit_cnt + 1'b1;
        if (mismatch) miss_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost <= 1'b0;
      released <= 1'b0;
    end else begin
      if (flag_clr)     arb_lost <= 1'b0;
      else if (set_ev)  arb_lost <= 1'b1;
      else if (bit_clr) arb_lost <= 1'b0;

      if (flag_clr || frame_start)  released <= 1'b0;
      else if (set_ev && release_en) released <= 1'b1;
    end
  end

  assign sda_oe = ~released;
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_in,
  input logic tx_active,
  input logic tx_bit,
  input logic frame_start,
  input logic flag_clr,
  input logic mode_byte,
  input logic release_en,
  input logic arb_lost,
  input logic sda_oe
);
  assert_release_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> arb_lost && $past(release_en));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !arb_lost);

  assert_release_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sda_oe && !flag_clr && !frame_start) |=> !sda_oe);

  assert_byte_post_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arb_lost) && $past(mode_byte)) |-> (!$past(scl_in) && $past(scl_in, 2)));

  assert_bit_loss_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arb_lost) && !$past(mode_byte)) |->
      ($past(scl_in) && !$past(scl_in, 2) && $past(tx_active) && $past(tx_bit) && !$past(sda_in)));

  assert_byte_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && mode_byte && !flag_clr) |=> arb_lost);
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk u_chk (.*);

// File: tb/i2c_arb_monitor_bench.sv
`timescale 1ns/1ps
module i2c_arb_monitor_bench;
  logic clk = 0, rst_n = 0;
  logic scl_in = 0, sda_in = 1, tx_active = 1, tx_bit = 1;
  logic frame_start = 0, flag_clr = 0, mode_byte = 0, release_en = 0;
  logic arb_lost, sda_oe;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_arb_monitor u_i2c_arb_monitor (.*);

  task automatic step;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic rise_bit(input logic txb, input logic sda);
    tx_bit = txb; sda_in = sda; step;
    scl_in = 1; step;
  endtask

  task automatic fall_bit;
    scl_in = 0; step;
    sda_in = 1;
  endtask

  task automatic new_frame;
    frame_start = 1; step; frame_start = 0;
  endtask

  task automatic clear_flag;
    flag_clr = 1; step; flag_clr = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step; step;
    chk("R1 flag", arb_lost, 1'b0);
    chk("R1 oe", sda_oe, 1'b1);
    rst_n = 1; step;

    // R2 / R3: exhaustive per-bit sweep
    for (int i = 0; i < 16; i++) begin
      logic init, act, txb, sda, exp;
      init = i[3]; act = i[2]; txb = i[1]; sda = i[0];
      mode_byte = 0; release_en = 0; tx_active = 1;
      new_frame; clear_flag;
      if (init) begin rise_bit(1, 0); fall_bit; end
      tx_active = act;
      rise_bit(txb, sda);
      exp = act ? (txb & ~sda) : init;
      chk(act ? "R2 per-bit compare" : "R3 idle hold", arb_lost, exp);
      fall_bit;
      tx_active = 1;
    end

    // R4 / R5 / R7: per-byte sweep of loss position and release
    for (int pos = 0; pos < 10; pos++) begin
      for (int rel = 0; rel < 2; rel++) begin
        logic lost;
        lost = (pos != 0);
        mode_byte = 1; release_en = rel[0]; tx_active = 1;
        clear_flag; new_frame;
        for (int b = 1; b <= 9; b++) begin
          rise_bit(1, (b == pos) ? 1'b0 : 1'b1);
          chk("R4 no change on rise", arb_lost, 1'b0);
          fall_bit;
          if (b < 9) chk("R4 no post before ninth fall", arb_lost, 1'b0);
        end
        chk("R4 post at ninth fall", arb_lost, lost);
        chk("R7 oe on post", sda_oe, !(lost && rel != 0));
        new_frame;
        for (int b = 1; b <= 9; b++) begin rise_bit(1, 1); fall_bit; end
        chk("R5 sticky across clean frame", arb_lost, lost);
        chk("R8 frame_start releases", sda_oe, 1'b1);
      end
    end

    // R6: loss before frame_start is forgotten
    mode_byte = 1; release_en = 0;
    clear_flag; new_frame;
    for (int b = 1; b <= 3; b++) begin rise_bit(1, (b == 3) ? 1'b0 : 1'b1); fall_bit; end
    new_frame;
    for (int b = 1; b <= 9; b++) begin rise_bit(1, 1); fall_bit; end
    chk("R6 stale loss dropped", arb_lost, 1'b0);

    // R6: counter reset - 9 bits counted from new frame, not earlier bits
    new_frame;
    for (int b = 1; b <= 5; b++) begin rise_bit(1, 1); fall_bit; end
    new_frame;
    for (int b = 1; b <= 8; b++) begin rise_bit(1, (b == 2) ? 1'b0 : 1'b1); fall_bit; end
    chk("R6 counter restarted", arb_lost, 1'b0);
    rise_bit(1, 1); fall_bit;
    chk("R6 post after restart", arb_lost, 1'b1);

    // R8: release persists after per-bit clear
    mode_byte = 0; release_en = 1;
    clear_flag; new_frame;
    rise_bit(1, 0);
    chk("R7 flag set", arb_lost, 1'b1);
    chk("R7 oe drops same cycle", sda_oe, 1'b0);
    fall_bit;
    rise_bit(1, 1);
    chk("R8 per-bit flag cleared", arb_lost, 1'b0);
    chk("R8 oe held", sda_oe, 1'b0);
    fall_bit;
    clear_flag;
    chk("R8 clear releases", sda_oe, 1'b1);

    // R7: no release when disabled
    release_en = 0;
    rise_bit(1, 0);
    chk("R7 flag set no release", arb_lost, 1'b1);
    chk("R7 oe kept", sda_oe, 1'b1);
    fall_bit;

    // R9: clear beats a simultaneous set
    release_en = 1; clear_flag;
    tx_bit = 1; sda_in = 0; step;
    scl_in = 1; flag_clr = 1; step; flag_clr = 0;
    chk("R9 clear wins flag", arb_lost, 1'b0);
    chk("R9 clear wins oe", sda_oe, 1'b1);
    fall_bit;

    finish_run();
  end
endmodule